// File: doc/BRIEF.md
# Race-to-Threshold Pulse Filter

This block is a nonlinear loop filter for a digital phase-locked loop. It watches two single-bit pulse streams, one that asks the oscillator to speed up and one that asks it to slow down. Both streams come from a phase-frequency detector and are already synchronous to the system clock. The block does not integrate them with weights. It runs a race instead. A window counter counts every pulse. Two side counters count the speed-up and slow-down pulses separately. A side counter that reaches the threshold N before the window counter reaches M emits a one-cycle decision pulse: CARRY for speed-up, BORROW for slow-down.

Any decision clears all three counters and a new window opens. A window that fills with no winner is also cleared, and it emits nothing. Small phase errors that flip back and forth are therefore absorbed, and only a clear majority inside a window reaches the oscillator. The ratio of N to M sets how strong that majority has to be. Elaboration stops if M is not greater than N.

Top module: `nbm_pulse_filter`

## Requirements
- R1: The window counter counts every input pulse. A cycle in which both the speed-up and the slow-down input are high adds two to the window count.
- R2: The clock edge that samples the speed-up pulse bringing the speed-up count to N sets `carryOut` high for exactly one cycle, unless the slow-down count also reaches N in that same cycle.
- R3: The clock edge that samples the slow-down pulse bringing the slow-down count to N sets `borrowOut` high for exactly one cycle, unless the speed-up count also reaches N in that same cycle.
- R4: When the window count reaches or passes M and neither side count reaches N, no output pulse is emitted and all three counts are cleared.
- R5: When a side count reaches N in the same cycle that the window count reaches or passes M, the side-count decision is emitted.
- R6: When both side counts reach N in the same cycle, neither output pulses and all counts are cleared.
- R7: Counters are cleared on the edge that registers a decision. A pulse arriving in the cycle in which `carryOut` or `borrowOut` is high is counted as the first pulse of the new window.
- R8: While `rst_n` is low, both outputs are low and every pulse is ignored. After reset, a full window of N speed-up pulses is needed for a decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| upPulse | input | 1 | One-cycle speed-up request from the phase detector |
| dnPulse | input | 1 | One-cycle slow-down request from the phase detector |
| carryOut | output | 1 | One-cycle pulse: speed-up requests won the window |
| borrowOut | output | 1 | One-cycle pulse: slow-down requests won the window |

## Verification
The hardest behaviour to reach is a window that closes with no winner, because nothing appears at the outputs when it happens. The stimulus fills a window with evenly mixed pulses, including a cycle with both inputs high that jumps the window count to M. It then sends speed-up pulses and counts how many are needed before a CARRY appears, which shows whether the side counts were really cleared. A tie, where both side counts reach N together, is only possible when M is at least 2N-1. A second instance with such parameters is driven to exactly N-1 on each side and then given both pulses at once.

// File: rtl/nbm_pkg.sv
package nbm_pkg;

  // Strobes from the decision logic to the counter datapath.
  typedef struct packed {
    logic incUp;     // count one speed-up pulse
    logic incDn;     // count one slow-down pulse
    logic clearAll;  // decision or window end: restart every counter
  } nbm_strobe_t;

endpackage

// File: rtl/nbm_counter.sv
module nbm_counter #(
  parameter int LIMIT = 4,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [1:0]    step,
  output logic [CW-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (clear)  count <= '0;
    else             count <= count + CW'(step);
  end

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) < LIMIT);

endmodule

// File: rtl/nbm_datapath.sv
module nbm_datapath
  import nbm_pkg::*;
#(
  parameter int N = 4,
  parameter int M = 6,
  localparam int NW = $clog2(N + 1),
  localparam int MW = $clog2(M + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  nbm_strobe_t strobe,
  output logic [NW-1:0] upCnt,
  output logic [NW-1:0] dnCnt,
  output logic [MW-1:0] totCnt
);

  logic [NW-1:0] sideCnt [2];
  logic [1:0]    totStep;

  for (genvar g = 0; g < 2; g++) begin : gSide
    logic [1:0] sideStep;
    assign sideStep = {1'b0, (g == 0) ? strobe.incUp : strobe.incDn};
    nbm_counter #(.LIMIT(N)) side_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (strobe.clearAll),
      .step  (sideStep),
      .count (sideCnt[g])
    );
  end

  assign upCnt   = sideCnt[0];
  assign dnCnt   = sideCnt[1];
  assign totStep = {1'b0, strobe.incUp} + {1'b0, strobe.incDn};

  nbm_counter #(.LIMIT(M)) window_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (strobe.clearAll),
    .step  (totStep),
    .count (totCnt)
  );

  // R1
  window_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(totCnt) == int'(upCnt) + int'(dnCnt));

endmodule

// File: rtl/nbm_control.sv
module nbm_control
  import nbm_pkg::*;
#(
  parameter int N = 4,
  parameter int M = 6,
  localparam int NW = $clog2(N + 1),
  localparam int MW = $clog2(M + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upPulse,
  input  logic          dnPulse,
  input  logic [NW-1:0] upCnt,
  input  logic [NW-1:0] dnCnt,
  input  logic [MW-1:0] totCnt,
  output nbm_strobe_t   strobe,
  output logic          carryOut,
  output logic          borrowOut
);

  logic [MW:0] sumNext;
  logic        upHit;
  logic        dnHit;
  logic        winEnd;

  always_comb begin
    sumNext = {1'b0, totCnt} + (MW+1)'(upPulse) + (MW+1)'(dnPulse);
    upHit   = upPulse && (upCnt == NW'(N - 1));
    dnHit   = dnPulse && (dnCnt == NW'(N - 1));
    winEnd  = sumNext >= (MW+1)'(M);
    strobe.incUp    = upPulse;
    strobe.incDn    = dnPulse;
    strobe.clearAll = upHit || dnHit || winEnd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carryOut  <= 1'b0;
      borrowOut <= 1'b0;
    end else begin
      carryOut  <= upHit && !dnHit;
      borrowOut <= dnHit && !upHit;
    end
  end

  // R6
  no_dual_decision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(carryOut && borrowOut));

  // R2
  carry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carryOut |-> $past(upPulse));

  // R3
  borrow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    borrowOut |-> $past(dnPulse));

  // R7
  decision_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (carryOut || borrowOut) |-> (totCnt == '0 && upCnt == '0 && dnCnt == '0));

endmodule

// File: rtl/nbm_pulse_filter.sv
module nbm_pulse_filter
  import nbm_pkg::*;
#(
  parameter int N = 4,
  parameter int M = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upPulse,
  input  logic dnPulse,
  output logic carryOut,
  output logic borrowOut
);

  localparam int NW = $clog2(N + 1);
  localparam int MW = $clog2(M + 1);

  if (M <= N || N < 1) begin : gBadParams
    $error("nbm_pulse_filter: window M must exceed threshold N, and N must be at least 1");
  end

  nbm_strobe_t   strobe;
  logic [NW-1:0] upCnt;
  logic [NW-1:0] dnCnt;
  logic [MW-1:0] totCnt;

  nbm_control #(.N(N), .M(M)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .upPulse   (upPulse),
    .dnPulse   (dnPulse),
    .upCnt     (upCnt),
    .dnCnt     (dnCnt),
    .totCnt    (totCnt),
    .strobe    (strobe),
    .carryOut  (carryOut),
    .borrowOut (borrowOut)
  );

  nbm_datapath #(.N(N), .M(M)) dp_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .upCnt  (upCnt),
    .dnCnt  (dnCnt),
    .totCnt (totCnt)
  );

endmodule

// File: tb/nbm_pulse_filter_tb.sv
module nbm_pulse_filter_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upPulse = 1'b0, dnPulse = 1'b0;
  logic carryOut, borrowOut;
  logic tUp = 1'b0, tDn = 1'b0;
  logic tCarry, tBorrow;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  nbm_pulse_filter #(.N(4), .M(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .upPulse(upPulse), .dnPulse(dnPulse),
    .carryOut(carryOut), .borrowOut(borrowOut));

  // Second instance with M >= 2N-1 so that a tie can happen.
  nbm_pulse_filter #(.N(3), .M(5)) tieDut_i (
    .clk(clk), .rst_n(rst_n), .upPulse(tUp), .dnPulse(tDn),
    .carryOut(tCarry), .borrowOut(tBorrow));

  // Each entry: {up, dn, expected carry, expected borrow}, requirement number.
  // Main instance has N=4, M=6.
  localparam int NV = 37;
  localparam logic [3:0] VEC [NV] = '{
    4'b1000, 4'b1000, 4'b1000, 4'b1010,          // R2: fourth UP wins
    4'b0100, 4'b0100, 4'b0100, 4'b0101,          // R7 first DN counted, R3 borrow
    4'b1000, 4'b0100, 4'b1000, 4'b0100,          // mixed, window count 4
    4'b1100,                                     // R1/R4: jump to 6, no winner
    4'b1000, 4'b1000, 4'b1000,                   // R4: three UPs, no carry
    4'b0100, 4'b0100, 4'b1110,                   // R5: UP hit beats window end
    4'b0000, 4'b0000,
    4'b0100, 4'b0100, 4'b0100, 4'b0000, 4'b0101, // idle not counted, R3
    4'b0000,
    4'b1000, 4'b0100, 4'b1000, 4'b0100, 4'b1000, 4'b0100, // R4 window ends on 6th
    4'b0100, 4'b0100, 4'b0100, 4'b0101           // R4: needs 4 fresh DNs
  };
  localparam int VREQ [NV] = '{
    2,2,2,2, 7,3,3,3, 7,1,1,1, 1, 4,4,4, 5,5,5, 5,5,
    3,3,3,3,3, 3, 4,4,4,4,4,4, 4,4,4,4
  };

  task automatic checkOut(input int req, input logic aC, input logic aB,
                          input logic eC, input logic eB);
    checks++;
    if (aC !== eC || aB !== eB) begin
      fails++;
      $display("FAIL R%0d: carry/borrow = %b/%b, expected %b/%b", req, aC, aB, eC, eB);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge.
  task automatic stepMain(input logic u, input logic d);
    upPulse = u; dnPulse = d;
    @(negedge clk);
  endtask

  task automatic stepTie(input logic u, input logic d);
    tUp = u; tDn = d;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++;
      $display("FAIL watchdog: cycles = %0d, expected < 50000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R8: pulses during reset are ignored
    upPulse = 1'b1; dnPulse = 1'b1;
    repeat (6) @(negedge clk);
    checkOut(8, carryOut, borrowOut, 1'b0, 1'b0);
    upPulse = 1'b0; dnPulse = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    checkOut(8, carryOut, borrowOut, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      stepMain(VEC[i][3], VEC[i][2]);
      checkOut(VREQ[i], carryOut, borrowOut, VEC[i][1], VEC[i][0]);
    end
    stepMain(1'b0, 1'b0);

    // R8: reset in the middle of a window discards partial counts
    stepMain(1'b1, 1'b0);
    stepMain(1'b1, 1'b0);
    stepMain(1'b1, 1'b0);
    checkOut(8, carryOut, borrowOut, 1'b0, 1'b0);
    upPulse = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    stepMain(1'b1, 1'b0);
    stepMain(1'b1, 1'b0);
    stepMain(1'b1, 1'b0);
    checkOut(8, carryOut, borrowOut, 1'b0, 1'b0);
    stepMain(1'b1, 1'b0);
    checkOut(8, carryOut, borrowOut, 1'b1, 1'b0);
    stepMain(1'b0, 1'b0);
    checkOut(2, carryOut, borrowOut, 1'b0, 1'b0);

    // R6: tie on the N=3, M=5 instance
    stepTie(1'b1, 1'b0);
    stepTie(1'b0, 1'b1);
    stepTie(1'b1, 1'b0);
    stepTie(1'b0, 1'b1);
    checkOut(6, tCarry, tBorrow, 1'b0, 1'b0);
    stepTie(1'b1, 1'b1);
    checkOut(6, tCarry, tBorrow, 1'b0, 1'b0);
    stepTie(1'b1, 1'b0);
    stepTie(1'b1, 1'b0);
    checkOut(6, tCarry, tBorrow, 1'b0, 1'b0);
    stepTie(1'b1, 1'b0);
    checkOut(6, tCarry, tBorrow, 1'b1, 1'b0);
    stepTie(1'b0, 1'b0);
    checkOut(2, tCarry, tBorrow, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule